// File: doc/BRIEF.md
# Indexed Colour Palette Port

This block is the register side and lookup path of a 256-colour palette. A host on a 32-bit bus picks an entry by writing its number to an index port. It then writes the entry's three colour components, red first, then green, then blue, to a colour port. The block takes one byte from each bus word, always the most significant byte. When the blue byte lands, the whole triple goes into the table in one step and the index moves to the next entry. A host can therefore load a run of entries after a single index write. Reads of the colour port walk the table in the same way.

The same index also selects one of four byte-wide control registers, reached through a separate control port. These are the pixel read mask, the blink mask, the overlay/command control and the test register. On the pixel side, an 8-bit pixel code is ANDed with the read mask and looked up, and the 24-bit colour appears one clock later. The analog converter, cursor overlay and video timing are not part of this block.

Top module: `palette_dac_port`

## Requirements
- R1: Every bus write uses only bits 31:24 of the word, and bits 23:0 have no effect. Every bus read returns its byte in bits 31:24, with bits 23:0 zero.
- R2: Bus select codes are 0 for the index port, 1 for the colour port and 2 for the control port. A write to the index port loads the index and returns the component phase to red. A read of the index port returns the current index.
- R3: After an index write, three writes to the colour port load the red, green and blue components of that entry, in that order.
- R4: After the blue write, the index increments by one and wraps from 255 to 0, and the phase returns to red.
- R5: The table entry changes only on the blue write. After only the red and green writes, a pixel lookup of that entry still returns the previous colour.
- R6: Index values 4, 5, 6 and 7 select the control registers: read mask, blink mask, command control and test. The control port reads and writes the selected register. At any other index, a control write changes nothing and a control read returns 0.
- R7: After reset, the index is 0, the read mask is 0xFF, the blink mask is 0x00, the command control is 0x73, the test register is 0x00 and the pixel output is 0.
- R8: The pixel output equals the entry at (pixel code AND read mask), given one clock after the code is presented. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R9: Reads of the colour port return red, green and blue of the current entry in phase order. They advance the phase and index exactly as writes do, and leave the table unchanged.
- R10: An index write in the middle of a colour sequence discards the staged components. The next colour write is treated as red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Bus write strobe, one access per cycle |
| busRdEn | input | 1 | Bus read strobe, one access per cycle |
| busSel | input | 2 | Port select: 0 index, 1 colour, 2 control |
| busWdata | input | 32 | Write data; the byte is in bits 31:24 |
| busRdata | output | 32 | Read data, valid in the cycle of the read strobe |
| pixIdx | input | 8 | Pixel colour code |
| pixRgb | output | 24 | Looked-up colour, one clock after pixIdx |

## Verification
The assertions assume that write and read strobes are never high in the same cycle, since that case is not defined. They also assume that select code 3 is never used while a strobe is active. The bench drives each bus access from its own task, which raises exactly one strobe with a legal select code for a single cycle, so neither assumption can be broken. The checks cover the index and phase sequence, the read lane format and the hold of state on idle cycles. Table contents are checked against a model that the bench builds from arithmetic colour formulas.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_COLOR = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } portSel_e;

  typedef struct packed {
    logic stageRed;
    logic stageGreen;
    logic commit;
    logic ctlWr;
  } dpStrobe_t;

endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int COMP_W   = 8,
  parameter int CTL_BASE = 4,
  parameter int CTL_NUM  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSel,
  input  logic [COMP_W-1:0] busByte,
  output logic [IDX_W-1:0]  idx,
  output phase_e            phase,
  output dpStrobe_t         strobe
);

  localparam logic [IDX_W-1:0] CTL_LO = IDX_W'(CTL_BASE);
  localparam logic [IDX_W-1:0] CTL_HI = IDX_W'(CTL_BASE + CTL_NUM - 1);

  logic ldIndex;
  logic colorAcc;
  logic colorWr;
  logic ctlHit;

  always_comb begin
    ldIndex  = busWrEn && (busSel == SEL_INDEX);
    colorWr  = busWrEn && (busSel == SEL_COLOR);
    colorAcc = colorWr || (busRdEn && !busWrEn && (busSel == SEL_COLOR));
    ctlHit   = (idx >= CTL_LO) && (idx <= CTL_HI);
  end

  always_comb begin
    strobe.stageRed   = colorWr && (phase == PH_RED);
    strobe.stageGreen = colorWr && (phase == PH_GREEN);
    strobe.commit     = colorWr && (phase == PH_BLUE);
    strobe.ctlWr      = busWrEn && (busSel == SEL_CTRL) && ctlHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (ldIndex) begin
      idx   <= busByte[IDX_W-1:0];
      phase <= PH_RED;
    end else if (colorAcc) begin
      case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/palette_dpath.sv
module palette_dpath
  import palette_pkg::*;
#(
  parameter int IDX_W       = 8,
  parameter int COMP_W      = 8,
  parameter int NUM_ENTRIES = 256,
  parameter int CTL_BASE    = 4,
  parameter int CTL_NUM     = 4,
  parameter logic [CTL_NUM*COMP_W-1:0] CTL_RST = 32'h00_73_00_FF
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [COMP_W-1:0]   busByte,
  input  logic                busRdEn,
  input  logic [1:0]          busSel,
  input  logic [IDX_W-1:0]    idx,
  input  phase_e              phase,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [COMP_W-1:0]   rdByte,
  output logic [3*COMP_W-1:0] pixRgb
);

  localparam int SLOT_W = (CTL_NUM > 1) ? $clog2(CTL_NUM) : 1;
  localparam logic [IDX_W-1:0] CTL_LO = IDX_W'(CTL_BASE);
  localparam logic [IDX_W-1:0] CTL_HI = IDX_W'(CTL_BASE + CTL_NUM - 1);

  logic [COMP_W-1:0]   stageR;
  logic [COMP_W-1:0]   stageG;
  logic [3*COMP_W-1:0] tbl [NUM_ENTRIES];
  logic [COMP_W-1:0]   ctlReg [CTL_NUM];
  logic [IDX_W-1:0]    slotWide;
  logic [SLOT_W-1:0]   slot;
  logic                ctlHit;
  logic [3*COMP_W-1:0] curEntry;
  logic [IDX_W-1:0]    maskedPix;

  always_comb begin
    slotWide = idx - CTL_LO;
    slot     = slotWide[SLOT_W-1:0];
    ctlHit   = (idx >= CTL_LO) && (idx <= CTL_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageR <= '0;
      stageG <= '0;
    end else begin
      if (strobe.stageRed)   stageR <= busByte;
      if (strobe.stageGreen) stageG <= busByte;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) tbl[idx] <= {stageR, stageG, busByte};
  end

  for (genvar g = 0; g < CTL_NUM; g++) begin : g_ctl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlReg[g] <= CTL_RST[g*COMP_W +: COMP_W];
      end else if (strobe.ctlWr && (slot == SLOT_W'(g))) begin
        ctlReg[g] <= busByte;
      end
    end
  end

  always_comb begin
    maskedPix = pixIdx & ctlReg[0][IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= tbl[maskedPix];
  end

  always_comb begin
    curEntry = tbl[idx];
    rdByte   = '0;
    if (busRdEn) begin
      case (busSel)
        SEL_INDEX: rdByte = COMP_W'(idx);
        SEL_COLOR: begin
          case (phase)
            PH_RED:   rdByte = curEntry[3*COMP_W-1 -: COMP_W];
            PH_GREEN: rdByte = curEntry[2*COMP_W-1 -: COMP_W];
            default:  rdByte = curEntry[COMP_W-1:0];
          endcase
        end
        SEL_CTRL:  rdByte = ctlHit ? ctlReg[slot] : '0;
        default:   rdByte = '0;
      endcase
    end
  end

endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
  import palette_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int COMP_W      = 8,
  parameter int NUM_ENTRIES = 256,
  parameter int CTL_BASE    = 4,
  parameter int CTL_NUM     = 4,
  parameter logic [CTL_NUM*COMP_W-1:0] CTL_RST = 32'h00_73_00_FF,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [1:0]          busSel,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixRgb
);

  localparam int PAD_W = BUS_W - COMP_W;

  logic [COMP_W-1:0] busByte;
  logic [COMP_W-1:0] rdByte;
  logic [IDX_W-1:0]  idx;
  phase_e            phase;
  dpStrobe_t         strobe;

  assign busByte  = busWdata[BUS_W-1 -: COMP_W];
  assign busRdata = {rdByte, {PAD_W{1'b0}}};

  palette_ctrl #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .CTL_BASE(CTL_BASE), .CTL_NUM(CTL_NUM)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busSel(busSel), .busByte(busByte), .idx(idx), .phase(phase),
    .strobe(strobe)
  );

  palette_dpath #(
    .IDX_W(IDX_W), .COMP_W(COMP_W), .NUM_ENTRIES(NUM_ENTRIES),
    .CTL_BASE(CTL_BASE), .CTL_NUM(CTL_NUM), .CTL_RST(CTL_RST)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busByte(busByte),
    .busRdEn(busRdEn), .busSel(busSel), .idx(idx), .phase(phase),
    .pixIdx(pixIdx), .rdByte(rdByte), .pixRgb(pixRgb)
  );

endmodule

// File: rtl/palette_dac_chk.sv
module palette_dac_chk #(
  parameter int BUS_W  = 32,
  parameter int COMP_W = 8,
  parameter int IDX_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [1:0]       busSel,
  input logic [BUS_W-1:0] busWdata,
  input logic [BUS_W-1:0] busRdata,
  input logic [IDX_W-1:0] idx,
  input logic [1:0]       phase
);

  logic colorAcc;
  assign colorAcc = (busWrEn || busRdEn) && (busSel == 2'd1);

  p_excl_in_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busRdEn) && !((busWrEn || busRdEn) && busSel == 2'd3));

  p_rd_lane_r1: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[BUS_W-COMP_W-1:0] == '0);

  p_index_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSel == 2'd0) |=>
      (idx == $past(busWdata[BUS_W-1 -: IDX_W])) && (phase == 2'd0));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    phase != 2'd3);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (colorAcc && phase != 2'd2) |=>
      (idx == $past(idx)) && (phase == $past(phase) + 2'd1));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rstN)
    (colorAcc && phase == 2'd2) |=>
      (idx == $past(idx) + 1'b1) && (phase == 2'd0));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!colorAcc && !(busWrEn && busSel == 2'd0)) |=>
      $stable(idx) && $stable(phase));

endmodule

bind palette_dac_port palette_dac_chk #(
  .BUS_W(BUS_W), .COMP_W(COMP_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busSel(busSel), .busWdata(busWdata), .busRdata(busRdata),
  .idx(idx), .phase(phase)
);

// File: tb/tb_palette_dac_port.sv
module tb_palette_dac_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIdx = '0;
  logic [23:0] pixRgb;

  int checks = 0;
  int errors = 0;
  logic [23:0] expTab [256];

  always #4 clk = ~clk;

  palette_dac_port dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busSel(busSel), .busWdata(busWdata), .busRdata(busRdata),
    .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] sel, input logic [7:0] b,
                          input logic [23:0] junk);
    @(negedge clk);
    busSel = sel; busWdata = {b, junk}; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] sel, output logic [7:0] b,
                         input string req);
    @(negedge clk);
    busSel = sel; busRdEn = 1'b1;
    #1;
    b = busRdata[31:24];
    check(busRdata[23:0] == 24'd0, "R1 low lane zero", busRdata, {b, 24'd0});
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic pixCheck(input logic [7:0] p, input logic [23:0] exp,
                          input string req);
    @(negedge clk);
    pixIdx = p;
    @(negedge clk);
    check(pixRgb == exp, req, {8'd0, pixRgb}, {8'd0, exp});
  endtask

  function automatic logic [23:0] colorOf(input int i);
    logic [7:0] r, g, b;
    r = 8'(i * 3 + 1);
    g = 8'(i) ^ 8'h5A;
    b = 8'(255 - i);
    return {r, g, b};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    logic [7:0] ctlExp [4];
    ctlExp[0] = 8'hFF; ctlExp[1] = 8'h00; ctlExp[2] = 8'h73; ctlExp[3] = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    check(pixRgb == 24'd0, "R7 pixel reset", {8'd0, pixRgb}, 32'd0);
    rstN = 1'b1;

    // R7: reset values
    busRead(2'd0, rb, "R7");
    check(rb == 8'd0, "R7 index reset", rb, 0);
    for (int k = 0; k < 4; k++) begin
      busWrite(2'd0, 8'(4 + k), 24'h0);
      busRead(2'd2, rb, "R7");
      check(rb == ctlExp[k], "R7 control reset", rb, ctlExp[k]);
    end

    // R3 R4 R1: fill all 256 entries after one index write, junk in low lane
    busWrite(2'd0, 8'd0, 24'hABCDEF);
    for (int i = 0; i < 256; i++) begin
      expTab[i] = colorOf(i);
      busWrite(2'd1, expTab[i][23:16], 24'(i * 77));
      busWrite(2'd1, expTab[i][15:8],  24'hFFFFFF);
      busWrite(2'd1, expTab[i][7:0],   24'h123456);
    end
    busRead(2'd0, rb, "R4");
    check(rb == 8'd0, "R4 index wrap", rb, 0);

    // R8: full sweep with mask 0xFF
    for (int p = 0; p < 256; p++) pixCheck(8'(p), expTab[p], "R8 lookup full mask");

    // R9: colour reads in phase order, index advance
    busWrite(2'd0, 8'd20, 24'h0);
    for (int e = 20; e < 22; e++) begin
      busRead(2'd1, rb, "R9"); check(rb == expTab[e][23:16], "R9 red read", rb, expTab[e][23:16]);
      busRead(2'd1, rb, "R9"); check(rb == expTab[e][15:8], "R9 green read", rb, expTab[e][15:8]);
      busRead(2'd1, rb, "R9"); check(rb == expTab[e][7:0], "R9 blue read", rb, expTab[e][7:0]);
    end
    busRead(2'd0, rb, "R9");
    check(rb == 8'd22, "R9 index after reads", rb, 22);
    pixCheck(8'd20, expTab[20], "R9 table unchanged");

    // R5 R10: partial sequence not committed, abort on index write
    busWrite(2'd0, 8'd10, 24'h0);
    busWrite(2'd1, 8'hAA, 24'h0);
    busWrite(2'd1, 8'hBB, 24'h0);
    pixCheck(8'd10, expTab[10], "R5 no commit before blue");
    busWrite(2'd0, 8'd10, 24'h0);
    busWrite(2'd1, 8'h01, 24'h0);
    busWrite(2'd1, 8'h02, 24'h0);
    pixCheck(8'd10, expTab[10], "R10 still old after restart");
    busWrite(2'd1, 8'h03, 24'h0);
    expTab[10] = 24'h010203;
    pixCheck(8'd10, expTab[10], "R10 restart committed as red first");
    busRead(2'd0, rb, "R4");
    check(rb == 8'd11, "R4 index increment", rb, 11);

    // R4: wrap from 255 mid-stream
    busWrite(2'd0, 8'd255, 24'h0);
    busWrite(2'd1, 8'h11, 24'h0);
    busWrite(2'd1, 8'h22, 24'h0);
    busWrite(2'd1, 8'h33, 24'h0);
    busWrite(2'd1, 8'h44, 24'h0);
    busWrite(2'd1, 8'h55, 24'h0);
    busWrite(2'd1, 8'h66, 24'h0);
    expTab[255] = 24'h112233; expTab[0] = 24'h445566;
    pixCheck(8'd255, expTab[255], "R4 entry 255");
    pixCheck(8'd0, expTab[0], "R4 wrapped entry 0");

    // R6: control write at non-control index has no effect
    busWrite(2'd0, 8'd9, 24'h0);
    busWrite(2'd2, 8'h55, 24'h0);
    busRead(2'd2, rb, "R6");
    check(rb == 8'd0, "R6 out-of-range read zero", rb, 0);
    pixCheck(8'd9, expTab[9], "R6 palette untouched");
    for (int k = 0; k < 4; k++) begin
      busWrite(2'd0, 8'(4 + k), 24'h0);
      busRead(2'd2, rb, "R6");
      check(rb == ctlExp[k], "R6 control unchanged", rb, ctlExp[k]);
    end
    busWrite(2'd0, 8'd5, 24'h0);
    busWrite(2'd2, 8'hC3, 24'hFFFFFF);
    busWrite(2'd0, 8'd7, 24'h0);
    busWrite(2'd2, 8'h3C, 24'h0);
    busWrite(2'd0, 8'd5, 24'h0);
    busRead(2'd2, rb, "R6"); check(rb == 8'hC3, "R6 blink mask", rb, 8'hC3);
    busWrite(2'd0, 8'd7, 24'h0);
    busRead(2'd2, rb, "R6"); check(rb == 8'h3C, "R6 test reg", rb, 8'h3C);

    // R8: read mask applied
    busWrite(2'd0, 8'd4, 24'h0);
    busWrite(2'd2, 8'h0F, 24'h0);
    for (int p = 0; p < 256; p++) pixCheck(8'(p), expTab[p & 8'h0F], "R8 masked lookup");
    busWrite(2'd2, 8'hF0, 24'h0);
    for (int p = 0; p < 256; p += 7) pixCheck(8'(p), expTab[p & 8'hF0], "R8 high mask");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule